// File: doc/BRIEF.md
# Region-Based Cache Color Mapper

This block sits between address translation and a shared last-level cache. Physical pages are grouped into memory regions by the low bits of their physical page number. Software gives each region a cache color through a small table. The cache set index is then built from that color and from the line-select bits of the address, not from the upper physical address bits. As a result, software can move a whole region to another slice of the cache without copying any page.

A small fully associative translation buffer holds, next to each translation, the color of its page. A lookup that hits therefore returns the physical page and the color together, with no table access. When a translation is missing, the requester supplies the physical page on a fill request. The block then reads the color from the region table with that page's region id, installs the entry and returns the full result. Writing a region entry invalidates every buffered translation of that region, so no out-of-date color is ever returned.

Every request gives one result on the cycle after it is accepted. The result holds a miss flag, the set index, the tag and the color.

Top module: `color_mapper`

## Requirements
- R1: After reset, every lookup misses and every region has color 0. A fill of any page right after reset therefore returns color 0.
- R2: A fill request (req_fill=1) gives, one cycle later, out_miss=0, out_tag equal to the supplied physical page and out_color equal to the table color of region ppn[7:0]. The same fill installs the translation together with that color.
- R3: A lookup (req_fill=0) that matches a valid entry gives, one cycle later, out_miss=0 and that entry's page and color. out_set is {color (5 bits, high), req_line (7 bits, low)}.
- R4: A lookup that matches no valid entry gives out_miss=1 with out_set, out_tag and out_color all zero.
- R5: A write of region r with color c makes every later fill of a page in region r return c.
- R6: A write of region r invalidates every buffered entry whose page lies in region r. Entries of other regions stay valid and unchanged.
- R7: A request in the same cycle as a write to its region uses the old color. A fill in that cycle is not kept in the buffer. From the next cycle on, the new color applies.
- R8: The buffer holds 8 entries and replaces them round-robin in fill order. After 9 distinct fills, the first one is gone.
- R9: A fill whose virtual page is already buffered overwrites that entry in place and does not advance the replacement order.
- R10: out_valid is high exactly in the cycle after a cycle with req_valid high. A write alone produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_fill | input | 1 | 1: fill with req_ppn; 0: lookup |
| req_vpn | input | 20 | Virtual page number |
| req_ppn | input | 23 | Physical page number (fill only) |
| req_line | input | 7 | Line index within the page |
| wr_en | input | 1 | Region table write strobe |
| wr_region | input | 8 | Region to write |
| wr_color | input | 5 | New color for the region |
| out_valid | output | 1 | Result valid |
| out_miss | output | 1 | Lookup found no translation |
| out_set | output | 12 | Cache set index {color, line} |
| out_tag | output | 23 | Cache tag (physical page number) |
| out_color | output | 5 | Color used for this access |

## Verification
The bench fills one virtual page with a page from every one of the 256 regions, so a table that is indexed by the wrong page bits, or a color field that is placed at the wrong set position, shows up as a wrong set index. It pushes 40 distinct fills through the 8-entry buffer and then looks all of them up. A replacement pointer that skips entries or favours one entry leaves the wrong translations resident. A region write that lands in the same cycle as a lookup or a fill to that region must return the old color and must not keep the fill. A design that bypasses the write would show the new color one cycle too early, and a design that keeps the fill would later hit with a stale color. Refilling a page that is already buffered must not evict a neighbouring entry.

// File: rtl/color_mapper.sv
module color_mapper #(
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 23,
  parameter int LINE_W   = 7,
  parameter int REGION_W = 8,
  parameter int COLOR_W  = 5,
  parameter int TLB_N    = 8,
  localparam int SET_W   = COLOR_W + LINE_W,
  localparam int REGIONS = 1 << REGION_W,
  localparam int IDX_W   = $clog2(TLB_N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_fill,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic [PPN_W-1:0]    req_ppn,
  input  logic [LINE_W-1:0]   req_line,
  input  logic                wr_en,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [COLOR_W-1:0]  wr_color,
  output logic                out_valid,
  output logic                out_miss,
  output logic [SET_W-1:0]    out_set,
  output logic [PPN_W-1:0]    out_tag,
  output logic [COLOR_W-1:0]  out_color
);

  logic [COLOR_W-1:0] region_color [REGIONS];
  logic [TLB_N-1:0]   t_valid;
  logic [VPN_W-1:0]   t_vpn [TLB_N];
  logic [PPN_W-1:0]   t_ppn [TLB_N];
  logic [COLOR_W-1:0] t_col [TLB_N];
  logic [IDX_W-1:0]   ptr;

  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   fill_idx;
  logic [COLOR_W-1:0] fill_color;
  logic               do_fill;
  logic               fill_killed;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (!hit && t_valid[i] && t_vpn[i] == req_vpn) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign do_fill     = req_valid && req_fill;
  assign fill_color  = region_color[req_ppn[REGION_W-1:0]];
  assign fill_idx    = hit ? hit_idx : ptr;
  assign fill_killed = wr_en && req_ppn[REGION_W-1:0] == wr_region;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < REGIONS; r++) region_color[r] <= '0;
    end else if (wr_en) begin
      region_color[wr_region] <= wr_color;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_valid <= '0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < TLB_N; i++) begin
        if (do_fill && fill_idx == IDX_W'(i)) begin
          t_valid[i] <= !fill_killed;
          t_vpn[i]   <= req_vpn;
          t_ppn[i]   <= req_ppn;
          t_col[i]   <= fill_color;
        end else if (wr_en && t_ppn[i][REGION_W-1:0] == wr_region) begin
          t_valid[i] <= 1'b0;
        end
      end
      if (do_fill && !hit)
        ptr <= (ptr == IDX_W'(TLB_N - 1)) ? '0 : ptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_set   <= '0;
      out_tag   <= '0;
      out_color <= '0;
    end else begin
      out_valid <= req_valid;
      if (do_fill) begin
        out_miss  <= 1'b0;
        out_tag   <= req_ppn;
        out_color <= fill_color;
        out_set   <= {fill_color, req_line};
      end else if (req_valid && hit) begin
        out_miss  <= 1'b0;
        out_tag   <= t_ppn[hit_idx];
        out_color <= t_col[hit_idx];
        out_set   <= {t_col[hit_idx], req_line};
      end else begin
        out_miss  <= req_valid;
        out_tag   <= '0;
        out_color <= '0;
        out_set   <= '0;
      end
    end
  end

endmodule

// File: rtl/color_mapper_chk.sv
module color_mapper_chk #(
  parameter int PPN_W   = 23,
  parameter int LINE_W  = 7,
  parameter int COLOR_W = 5,
  localparam int SET_W  = COLOR_W + LINE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_fill,
  input logic [PPN_W-1:0]   req_ppn,
  input logic [LINE_W-1:0]  req_line,
  input logic               out_valid,
  input logic               out_miss,
  input logic [SET_W-1:0]   out_set,
  input logic [PPN_W-1:0]   out_tag,
  input logic [COLOR_W-1:0] out_color
);

  p_valid_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));

  p_fill_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_fill |=> out_valid && !out_miss && out_tag == $past(req_ppn)
      && out_set[LINE_W-1:0] == $past(req_line));

  p_miss_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_miss |-> out_set == '0 && out_tag == '0 && out_color == '0);

  p_hit_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_fill |=> out_miss || out_set[LINE_W-1:0] == $past(req_line));

  p_set_color_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_miss |-> out_set[SET_W-1:LINE_W] == out_color);

endmodule

bind color_mapper color_mapper_chk #(.PPN_W(PPN_W), .LINE_W(LINE_W), .COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
  .req_ppn(req_ppn), .req_line(req_line), .out_valid(out_valid), .out_miss(out_miss),
  .out_set(out_set), .out_tag(out_tag), .out_color(out_color));

// File: tb/sim_color_mapper.sv
module sim_color_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_fill = 0, wr_en = 0;
  logic [19:0] req_vpn = 0;
  logic [22:0] req_ppn = 0;
  logic [6:0]  req_line = 0;
  logic [7:0]  wr_region = 0;
  logic [4:0]  wr_color = 0;
  logic        out_valid, out_miss;
  logic [11:0] out_set;
  logic [22:0] out_tag;
  logic [4:0]  out_color;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int rt [256];
  bit mv [8];
  int mvpn [8];
  int mppn [8];
  int mcol [8];
  int mptr = 0;

  always #10 clk = ~clk;

  color_mapper u0 (.*);

  function automatic int find(int vpn);
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic step(bit v, bit f, int vpn, int ppn, int line,
                      bit w, int wreg, int wcol, string tag);
    bit ev, em; int es, et, ec, hi, idx;
    @(negedge clk);
    req_valid = v; req_fill = f; req_vpn = vpn[19:0]; req_ppn = ppn[22:0];
    req_line = line[6:0]; wr_en = w; wr_region = wreg[7:0]; wr_color = wcol[4:0];
    ev = v; em = 0; es = 0; et = 0; ec = 0;
    hi = find(vpn);
    if (v && f) begin
      ec = rt[ppn & 255]; et = ppn; es = ec * 128 + line;
    end else if (v && hi >= 0) begin
      ec = mcol[hi]; et = mppn[hi]; es = ec * 128 + line;
    end else if (v) em = 1;
    @(posedge clk); #2;
    n_chk++;
    if (out_valid !== ev || (ev && (out_miss !== em || out_set !== es[11:0] ||
        out_tag !== et[22:0] || out_color !== ec[4:0]))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b m=%0b set=%0h tag=%0h col=%0d exp v=%0b m=%0b set=%0h tag=%0h col=%0d",
               tag, out_valid, out_miss, out_set, out_tag, out_color, ev, em, es, et, ec);
    end
    if (v && f) begin
      idx = (hi >= 0) ? hi : mptr;
      if (hi < 0) mptr = (mptr + 1) % 8;
      mv[idx] = 1; mvpn[idx] = vpn; mppn[idx] = ppn; mcol[idx] = rt[ppn & 255];
    end
    if (w) begin
      rt[wreg] = wcol;
      for (int i = 0; i < 8; i++) if ((mppn[i] & 255) == wreg) mv[i] = 0;
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pp;
    for (int r = 0; r < 256; r++) rt[r] = 0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mvpn[i] = 0; mppn[i] = 0; mcol[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    for (int i = 0; i < 8; i++) step(1, 0, 100 + i, 0, i, 0, 0, 0, "R1 reset miss");
    for (int i = 0; i < 8; i++) step(1, 1, 100 + i, 'h1000 * i + i, 3 * i, 0, 0, 0, "R1 color 0");
    for (int i = 0; i < 8; i++) step(1, 0, 100 + i, 0, 127 - i, 0, 0, 0, "R3 hit");
    for (int r = 0; r < 256; r++) step(0, 0, 0, 0, 0, 1, r, (r * 11 + 5) & 31, "R10 write only");
    for (int i = 0; i < 8; i++) step(1, 0, 100 + i, 0, i, 0, 0, 0, "R6 invalidated");
    for (int r = 0; r < 256; r++) step(1, 1, 500, r + 'h4100, r & 127, 0, 0, 0, "R2 region sweep");
    step(1, 1, 501, 'h100, 9, 0, 0, 0, "R2 fill");
    for (int k = 0; k < 40; k++) step(1, 1, 200 + k, k * 521 + 3, k, 0, 0, 0, "R5 fill");
    for (int k = 0; k < 40; k++) step(1, 0, 200 + k, 0, k + 1, 0, 0, 0, "R8 residency");
    step(1, 1, 239, 'h7abcd, 4, 0, 0, 0, "R9 refill");
    for (int k = 32; k < 40; k++) step(1, 0, 200 + k, 0, k, 0, 0, 0, "R9 kept");
    pp = 35 * 521 + 3;
    step(0, 0, 0, 0, 0, 1, pp & 255, 17, "R6 write");
    for (int k = 32; k < 40; k++) step(1, 0, 200 + k, 0, k, 0, 0, 0, "R6 isolate");
    pp = 36 * 521 + 3;
    step(1, 0, 236, 0, 2, 1, pp & 255, 9, "R7 old color hit");
    step(1, 0, 236, 0, 2, 0, 0, 0, "R7 after write");
    step(1, 1, 236, pp, 5, 1, pp & 255, 22, "R7 old color fill");
    step(1, 0, 236, 0, 5, 0, 0, 0, "R7 fill dropped");
    step(1, 1, 236, pp, 6, 0, 0, 0, "R7 new color");
    step(1, 0, 236, 0, 7, 0, 0, 0, "R3 hit new");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule